// File: doc/BRIEF.md
# Transmit FIFO Trigger-Level Controller

This block keeps the fill threshold at which a transmit FIFO starts handing buffered data to the transmitter. The threshold counts 64-byte units and adapts at run time. An increase request, usually raised after a transmit underrun, moves the threshold up by half of the distance that remains to the ceiling. A decrease request moves it down by exactly one unit. A request that would give no upward movement, or that would take the level below the floor, is refused. The level then stays as it was and an error flag reports the refusal.

Each accepted request runs a short, fixed sequence. First the global interrupt enable seen by the rest of the chip is forced low. Then the new level is computed and either written or refused. Finally the enable state from just before the request is put back, and a one-cycle acknowledge is given. Outside an update, the outgoing enable follows the incoming one, one cycle later. Neither the FIFO nor the transmitter is part of this block.

Top module: `tx_trig_ctl`

## Requirements
- R1: After reset, `thr_lvl` equals `THR_MIN` (default 1, one 64-byte unit), `upd_ack` is 0, `upd_err` is 0 and `gie_out` is 0.
- R2: An accepted increase sets `thr_lvl` to `thr + floor((THR_MAX - thr) / 2)` whenever that step is non-zero, and reports `upd_err` = 0.
- R3: An accepted increase whose step is zero is refused. This covers `thr_lvl` equal to `THR_MAX` or to `THR_MAX - 1`. `thr_lvl` stays unchanged and `upd_err` = 1.
- R4: An accepted decrease with `thr_lvl > THR_MIN` lowers `thr_lvl` by exactly 1 and reports `upd_err` = 0.
- R5: An accepted decrease with `thr_lvl == THR_MIN` is refused. `thr_lvl` stays unchanged and `upd_err` = 1.
- R6: When `inc_req` and `dec_req` are both high in the accepting cycle, only the increase is carried out.
- R7: While idle, `gie_out` takes the value of `gie_in` one cycle later. From the accepting edge until the completing edge, `gie_out` is 0. At the completing edge it is restored to the value it had just before the accepting edge, for both applied and refused requests.
- R8: A request sampled at edge t0 gives the new `thr_lvl` after edge t0+1. `upd_ack` is high for exactly the one cycle after edge t0+2. `upd_err` changes only together with `upd_ack` and holds its value until the next acknowledge.
- R9: Requests sampled at the two edges after the accepting edge (update in progress) are ignored. They produce no acknowledge and no change of `thr_lvl`. A request sampled at t0+3 is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_req | input | 1 | One-cycle pulse requesting a higher threshold |
| dec_req | input | 1 | One-cycle pulse requesting a lower threshold |
| gie_in | input | 1 | Requested global interrupt enable |
| thr_lvl | output | THR_W | Current threshold in 64-byte units |
| upd_ack | output | 1 | One-cycle pulse when a request completes |
| upd_err | output | 1 | 1 when the last completed request was refused |
| gie_out | output | 1 | Global interrupt enable passed to the chip |

## Verification
Some properties are checked on every cycle. The threshold always stays within its bounds. Any change of the threshold is followed by a successful acknowledge, and the acknowledge is a single pulse. The error flag moves only together with the acknowledge. The outgoing interrupt enable is low while an update is in progress. A successful decrease lowers the level by exactly one. Other behaviour can only be shown by the bench's scenarios. These are the exact halving sequence toward the ceiling, refusal at the top and at the floor, the inc-over-dec priority, dropping of requests during an update, and restoring the enable from before the request even after `gie_in` has changed.

// File: rtl/tx_trig_pkg.sv
package tx_trig_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_MASK    = 2'd1,
      ST_RESTORE = 2'd2
   } trig_state_t;

endpackage

// File: rtl/tx_trig_step.sv
module tx_trig_step #(
   parameter int THR_W   = 6,
   parameter int THR_MIN = 1,
   parameter int THR_MAX = 63
) (
   input  logic [THR_W-1:0] cur_lvl,
   input  logic             op_inc,
   output logic [THR_W-1:0] nxt_lvl,
   output logic             step_ok
);
   localparam logic [THR_W-1:0] MIN_V = THR_W'(THR_MIN);
   localparam logic [THR_W-1:0] MAX_V = THR_W'(THR_MAX);

   logic [THR_W-1:0] gap;
   logic [THR_W-1:0] up_step;
   logic [THR_W-1:0] up_lvl;
   logic [THR_W-1:0] dn_lvl;
   logic             up_ok;
   logic             dn_ok;

   always_comb begin
      gap     = MAX_V - cur_lvl;
      up_step = gap >> 1;
      up_lvl  = cur_lvl + up_step;
      up_ok   = (up_step != '0);
      dn_lvl  = cur_lvl - THR_W'(1);
      dn_ok   = (cur_lvl > MIN_V);
      nxt_lvl = op_inc ? up_lvl : dn_lvl;
      step_ok = op_inc ? up_ok : dn_ok;
   end

endmodule

// File: rtl/tx_trig_irq_gate.sv
module tx_trig_irq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic gie_in,
   input  logic accept,
   input  logic finish,
   input  logic busy,
   output logic gie_out
);
   logic saved_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_out <= 1'b0;
         saved_q <= 1'b0;
      end else if (accept) begin
         saved_q <= gie_out;
         gie_out <= 1'b0;
      end else if (finish) begin
         gie_out <= saved_q;
      end else if (!busy) begin
         gie_out <= gie_in;
      end
   end

endmodule

// File: rtl/tx_trig_fsm.sv
module tx_trig_fsm
   import tx_trig_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic inc_req,
   input  logic dec_req,
   input  logic step_ok,
   output logic busy,
   output logic accept,
   output logic commit,
   output logic finish,
   output logic op_inc,
   output logic upd_ack,
   output logic upd_err
);
   trig_state_t state_q;
   logic        ok_q;

   always_comb begin
      accept = (state_q == ST_IDLE) && (inc_req || dec_req);
      commit = (state_q == ST_MASK);
      finish = (state_q == ST_RESTORE);
      busy   = (state_q != ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_inc  <= 1'b0;
         ok_q    <= 1'b0;
         upd_ack <= 1'b0;
         upd_err <= 1'b0;
      end else begin
         upd_ack <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  op_inc  <= inc_req;
                  state_q <= ST_MASK;
               end
            end
            ST_MASK: begin
               ok_q    <= step_ok;
               state_q <= ST_RESTORE;
            end
            ST_RESTORE: begin
               upd_ack <= 1'b1;
               upd_err <= !ok_q;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tx_trig_ctl.sv
module tx_trig_ctl #(
   parameter int THR_W   = 6,
   parameter int THR_MIN = 1,
   parameter int THR_MAX = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_req,
   input  logic             dec_req,
   input  logic             gie_in,
   output logic [THR_W-1:0] thr_lvl,
   output logic             upd_ack,
   output logic             upd_err,
   output logic             gie_out
);
   localparam logic [THR_W-1:0] RST_LVL = THR_W'(THR_MIN);

   if (THR_W < 2) begin : g_bad_width
      $error("tx_trig_ctl: THR_W must be at least 2");
   end
   if (THR_MIN < 0 || THR_MIN >= THR_MAX) begin : g_bad_range
      $error("tx_trig_ctl: THR_MIN must be below THR_MAX");
   end
   if (THR_MAX > (1 << THR_W) - 1) begin : g_bad_max
      $error("tx_trig_ctl: THR_MAX does not fit in THR_W bits");
   end

   logic             busy;
   logic             accept;
   logic             commit;
   logic             finish;
   logic             op_inc;
   logic             step_ok;
   logic [THR_W-1:0] nxt_lvl;

   tx_trig_step #(
      .THR_W   (THR_W),
      .THR_MIN (THR_MIN),
      .THR_MAX (THR_MAX)
   ) u_step (
      .cur_lvl (thr_lvl),
      .op_inc  (op_inc),
      .nxt_lvl (nxt_lvl),
      .step_ok (step_ok)
   );

   tx_trig_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_req (inc_req),
      .dec_req (dec_req),
      .step_ok (step_ok),
      .busy    (busy),
      .accept  (accept),
      .commit  (commit),
      .finish  (finish),
      .op_inc  (op_inc),
      .upd_ack (upd_ack),
      .upd_err (upd_err)
   );

   tx_trig_irq_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .gie_in  (gie_in),
      .accept  (accept),
      .finish  (finish),
      .busy    (busy),
      .gie_out (gie_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_lvl <= RST_LVL;
      end else if (commit && step_ok) begin
         thr_lvl <= nxt_lvl;
      end
   end

endmodule

// File: rtl/tx_trig_ctl_chk.sv
module tx_trig_ctl_chk #(
   parameter int THR_W   = 6,
   parameter int THR_MIN = 1,
   parameter int THR_MAX = 63
) (
   input logic             clk,
   input logic             rst_n,
   input logic [THR_W-1:0] thr_lvl,
   input logic             upd_ack,
   input logic             upd_err,
   input logic             gie_out,
   input logic             busy,
   input logic             op_inc
);
   localparam logic [THR_W-1:0] MIN_V = THR_W'(THR_MIN);
   localparam logic [THR_W-1:0] MAX_V = THR_W'(THR_MAX);

   AST_THR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_lvl >= MIN_V) && (thr_lvl <= MAX_V)); // R1

   AST_CHANGE_THEN_OK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(thr_lvl) |=> (upd_ack && !upd_err)); // R2

   AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_ack && !upd_err && !op_inc) |-> (thr_lvl == $past(thr_lvl, 2) - THR_W'(1))); // R4

   AST_GIE_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !gie_out); // R7

   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_ack |=> !upd_ack); // R8

   AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(upd_err) |-> upd_ack); // R8

endmodule

bind tx_trig_ctl tx_trig_ctl_chk #(
   .THR_W   (THR_W),
   .THR_MIN (THR_MIN),
   .THR_MAX (THR_MAX)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .thr_lvl (thr_lvl),
   .upd_ack (upd_ack),
   .upd_err (upd_err),
   .gie_out (gie_out),
   .busy    (busy),
   .op_inc  (op_inc)
);

// File: tb/test_tx_trig_ctl.sv
module test_tx_trig_ctl;
   localparam int THR_W   = 6;
   localparam int THR_MIN = 1;
   localparam int THR_MAX = 63;
   localparam int NV      = 12;

   // op: 1 = increase, 2 = decrease, 3 = both
   localparam int V_OP  [NV] = '{2, 1, 1, 2, 1, 1, 1, 3, 1, 1, 2, 2};
   localparam int V_THR [NV] = '{1, 32, 47, 46, 54, 58, 60, 61, 62, 62, 61, 60};
   localparam int V_ERR [NV] = '{1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             inc_req = 1'b0;
   logic             dec_req = 1'b0;
   logic             gie_in = 1'b0;
   logic [THR_W-1:0] thr_lvl;
   logic             upd_ack;
   logic             upd_err;
   logic             gie_out;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   tx_trig_ctl #(
      .THR_W   (THR_W),
      .THR_MIN (THR_MIN),
      .THR_MAX (THR_MAX)
   ) i_tx_trig_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_req (inc_req),
      .dec_req (dec_req),
      .gie_in  (gie_in),
      .thr_lvl (thr_lvl),
      .upd_ack (upd_ack),
      .upd_err (upd_err),
      .gie_out (gie_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n   = 1'b0;
      inc_req = 1'b0;
      dec_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_req(input int op, output int o_thr, output int o_err,
                         output int o_ack, output int o_gbusy);
      int g;
      @(negedge clk);
      inc_req = (op == 1 || op == 3);
      dec_req = (op >= 2);
      @(negedge clk);
      inc_req = 1'b0;
      dec_req = 1'b0;
      g = gie_out;
      @(negedge clk);
      g = g | gie_out;
      @(negedge clk);
      o_thr   = thr_lvl;
      o_err   = upd_err;
      o_ack   = upd_ack;
      o_gbusy = g;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int t, e, a, g;
      int ack_cnt;
      do_reset();
      // R1 reset state
      chk("R1 thr", thr_lvl, THR_MIN);
      chk("R1 ack", upd_ack, 0);
      chk("R1 err", upd_err, 0);
      chk("R1 gie", gie_out, 0);

      // R7 idle follow
      gie_in = 1'b1;
      repeat (2) @(negedge clk);
      chk("R7 idle follow", gie_out, 1);

      // vector table: R2 R3 R4 R5 R6 R8
      for (int i = 0; i < NV; i++) begin
         do_req(V_OP[i], t, e, a, g);
         chk($sformatf("R2/R3/R4/R5/R6 vec%0d thr", i), t, V_THR[i]);
         chk($sformatf("R8 vec%0d err", i), e, V_ERR[i]);
         chk($sformatf("R8 vec%0d ack", i), a, 1);
         chk($sformatf("R7 vec%0d gie busy", i), g, 0);
         chk($sformatf("R7 vec%0d gie restored", i), gie_out, 1);
         @(negedge clk);
         chk($sformatf("R8 vec%0d ack single", i), upd_ack, 0);
      end

      // R3: increase refused near the ceiling
      do_req(1, t, e, a, g);
      chk("R3 top inc thr", t, 60 + 1);
      do_req(1, t, e, a, g);
      chk("R3 inc thr", t, 62);
      do_req(1, t, e, a, g);
      chk("R3 refused thr", t, 62);
      chk("R3 refused err", e, 1);

      // R9: requests during an update are ignored
      ack_cnt = 0;
      @(negedge clk);
      inc_req = 1'b0;
      dec_req = 1'b1;
      @(negedge clk);
      dec_req = 1'b1;            // sampled while busy
      @(negedge clk);
      ack_cnt += upd_ack;
      @(negedge clk);
      ack_cnt += upd_ack;
      dec_req = 1'b0;
      chk("R9 first thr", thr_lvl, 61);
      repeat (4) begin
         @(negedge clk);
         ack_cnt += upd_ack;
      end
      chk("R9 ack count", ack_cnt, 1);
      chk("R9 thr unchanged", thr_lvl, 61);

      // R7: enable restored to its pre-request value
      do_req(2, t, e, a, g);
      chk("R4 dec thr", t, 60);
      @(negedge clk);
      inc_req = 1'b1;
      @(negedge clk);
      inc_req = 1'b0;
      gie_in  = 1'b0;
      @(negedge clk);
      chk("R7 low while busy", gie_out, 0);
      @(negedge clk);
      chk("R7 restore saved", gie_out, 1);
      chk("R2 thr 61", thr_lvl, 61);
      @(negedge clk);
      chk("R7 follow after", gie_out, 0);
      do_req(2, t, e, a, g);
      chk("R7 restore zero", gie_out, 0);

      // R4/R5: walk down to the floor
      do_reset();
      do_req(1, t, e, a, g);
      chk("R2 from reset", t, 32);
      for (int k = 31; k >= 1; k--) begin
         do_req(2, t, e, a, g);
         chk($sformatf("R4 walk %0d", k), t, k);
         if (k == 1) chk("R4 walk err", e, 0);
      end
      do_req(2, t, e, a, g);
      chk("R5 floor thr", t, THR_MIN);
      chk("R5 floor err", e, 1);
      repeat (3) @(negedge clk);
      chk("R8 err held", upd_err, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule